// File: doc/BRIEF.md
# Arbitrated Register Access Channel

This block is the host-facing end of a serial path to a remote power-management device whose registers are 16 bits wide. Those registers sit in a 16-bit address space at a stride of two bytes. Software composes one 32-bit command word and writes it. The word holds a direction flag, a halfword address and write data. Software then polls a single 32-bit status word until the transfer is finished. The channel latches the command and raises a request toward a serial engine. It follows that engine's accept/finish handshake and captures the returned read data.

The channel FSM has four encoded states, and software sees them in the status word. A write runs through request and wait and then returns to idle by itself. A read parks in a wait-for-valid-clear state, where the captured data stays frozen until software writes a 1 to the valid-clear register. The channel accepts a command only when it is idle and software has set the init-done register. A command that arrives while a transfer is in flight is dropped, and a sticky error flag is raised.

Top module: `reg_access_chan`

## Requirements
- R1: After reset the status word reads 0x0010_0000: state IDLE, no request pending, sync-idle set, init-done clear, read data zero. The error output and the serial request are low.
- R2: An accepted command word drives the serial request pins while the request is pending. Bit 31 is the write flag (1 = write, 0 = read), bits 30:16 are the halfword address and bits 15:0 are the write data.
- R3: Status word layout: bits 15:0 read data, 18:16 FSM state, 19 request pending, 20 sync-idle, 21 init-done. Bits 31:22 always read zero.
- R4: State codes are IDLE=0, REQ=2, WAIT_FOR_IDLE=4 and WAIT_FOR_VALID_CLEAR=6, and no other value appears. A write goes 0→2→4→0 and needs no valid-clear.
- R5: When the serial engine finishes a read, the FSM enters state 6 on the next edge with the engine's data in bits 15:0. It holds both until valid-clear.
- R6: Host select 1 is the valid-clear register. A write with bit 0 = 1 in state 6 returns the FSM to IDLE. A write with bit 0 = 0 changes nothing.
- R7: A command (host select 0) written while init-done is set and the state is not IDLE is ignored. It sets the error output, which stays set until reset.
- R8: Host select 2 is the init-done register (bit 0), shown in status bit 21. While it is 0, commands are ignored without raising the error.
- R9: Sync-idle (status bit 20) is low from the edge that accepts a command until the edge on which the engine reports the transfer finished.
- R10: The serial request stays high until the engine's accept pulse is sampled and drops on the following edge. The FSM then moves from REQ to WAIT_FOR_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Host write strobe, one cycle per write |
| bus_sel_i | input | 2 | Host register select: 0 command, 1 valid-clear, 2 init-done |
| bus_wdata_i | input | 32 | Host write data |
| status_o | output | 32 | Status word |
| err_o | output | 1 | Sticky error: command dropped while busy |
| ser_req_o | output | 1 | Request to serial engine |
| ser_we_o | output | 1 | Request is a write |
| ser_addr_o | output | 15 | Halfword address of the request |
| ser_wdata_o | output | 16 | Write data of the request |
| ser_ack_i | input | 1 | Engine accepted the request (pulse) |
| ser_done_i | input | 1 | Engine finished the transfer (pulse) |
| ser_rdata_i | input | 16 | Read data, valid with ser_done_i |

## Verification
The properties watch the handshake and the state word on every cycle. They check that a request is held until it is accepted and then dropped. They check that state 6 and its data stay frozen without a valid-clear, that only the four codes appear and that the error is sticky. They also check that commands go nowhere while init-done is clear, that the finish edge lands in the right state and that sync-idle is low whenever a request is up. Only the bench scenarios show that the data at a given address is correct end to end: what a read returns after earlier writes, and that a command dropped while busy really left the remote register untouched. A fixed-seed random stream of reads and writes against a latency-randomised engine stub covers these, alongside directed cases.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 15;
    localparam int BUS_W  = 1 + ADDR_W + DATA_W;
    localparam int SEL_W  = 2;
    localparam int ST_W   = 3;

    localparam int WE_BIT    = BUS_W - 1;
    localparam int ADDR_MSB  = WE_BIT - 1;
    localparam int STATE_LSB = DATA_W;
    localparam int REQ_BIT   = STATE_LSB + ST_W;
    localparam int SYNC_BIT  = REQ_BIT + 1;
    localparam int INIT_BIT  = SYNC_BIT + 1;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE      = 3'd0,
        ST_REQ       = 3'd2,
        ST_WAIT_IDLE = 3'd4,
        ST_WAIT_VCLR = 3'd6
    } chan_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 2'd0,
        SEL_VCLR = 2'd1,
        SEL_INIT = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } chan_cmd_t;
endpackage

// File: rtl/rac_host_regs.sv
module rac_host_regs
    import rac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             fsm_idle,
    output logic             cmd_fire,
    output chan_cmd_t        cmd,
    output logic             vclr_pulse,
    output logic             init_done,
    output logic             err
);
    typedef struct packed {
        logic init_done;
        logic err;
    } hregs_t;

    hregs_t    r_d, r_q;
    host_sel_e sel;
    logic      cmd_hit;

    always_comb begin
        sel        = host_sel_e'(bus_sel);
        cmd_hit    = bus_we && (sel == SEL_CMD);
        cmd.wr     = bus_wdata[WE_BIT];
        cmd.addr   = bus_wdata[ADDR_MSB -: ADDR_W];
        cmd.data   = bus_wdata[DATA_W-1:0];
        cmd_fire   = cmd_hit && r_q.init_done && fsm_idle;
        vclr_pulse = bus_we && (sel == SEL_VCLR) && bus_wdata[0];

        r_d = r_q;
        if (cmd_hit && r_q.init_done && !fsm_idle) begin
            r_d.err = 1'b1;
        end
        if (bus_we && (sel == SEL_INIT)) begin
            r_d.init_done = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign init_done = r_q.init_done;
    assign err       = r_q.err;
endmodule

// File: rtl/rac_chan_fsm.sv
module rac_chan_fsm
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  chan_cmd_t         cmd,
    input  logic              vclr_pulse,
    input  logic              ser_ack,
    input  logic              ser_done,
    input  logic [DATA_W-1:0] ser_rdata,
    output chan_state_e       state,
    output logic              req,
    output logic              sync_idle,
    output chan_cmd_t         cur_cmd,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        chan_state_e       state;
        logic              req;
        logic              sync_idle;
        chan_cmd_t         cmd;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            ST_IDLE: begin
                if (cmd_fire) begin
                    f_d.state     = ST_REQ;
                    f_d.req       = 1'b1;
                    f_d.sync_idle = 1'b0;
                    f_d.cmd       = cmd;
                end
            end
            ST_REQ: begin
                if (ser_ack) begin
                    f_d.state = ST_WAIT_IDLE;
                    f_d.req   = 1'b0;
                end
            end
            ST_WAIT_IDLE: begin
                if (ser_done) begin
                    f_d.sync_idle = 1'b1;
                    if (f_q.cmd.wr) begin
                        f_d.state = ST_IDLE;
                    end else begin
                        f_d.state = ST_WAIT_VCLR;
                        f_d.rdata = ser_rdata;
                    end
                end
            end
            ST_WAIT_VCLR: begin
                if (vclr_pulse) begin
                    f_d.state = ST_IDLE;
                end
            end
            default: begin
                f_d.state = ST_IDLE;
                f_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state     <= ST_IDLE;
            f_q.req       <= 1'b0;
            f_q.sync_idle <= 1'b1;
            f_q.cmd       <= '0;
            f_q.rdata     <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state     = f_q.state;
    assign req       = f_q.req;
    assign sync_idle = f_q.sync_idle;
    assign cur_cmd   = f_q.cmd;
    assign rdata     = f_q.rdata;
endmodule

// File: rtl/rac_status_pack.sv
module rac_status_pack
    import rac_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  chan_state_e       state,
    input  logic              req,
    input  logic              sync_idle,
    input  logic              init_done,
    output logic [BUS_W-1:0]  status
);
    always_comb begin
        status                         = '0;
        status[DATA_W-1:0]             = rdata;
        status[STATE_LSB +: ST_W]      = state;
        status[REQ_BIT]                = req;
        status[SYNC_BIT]               = sync_idle;
        status[INIT_BIT]               = init_done;
    end
endmodule

// File: rtl/reg_access_chan.sv
module reg_access_chan
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [SEL_W-1:0]  bus_sel_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  status_o,
    output logic              err_o,
    output logic              ser_req_o,
    output logic              ser_we_o,
    output logic [ADDR_W-1:0] ser_addr_o,
    output logic [DATA_W-1:0] ser_wdata_o,
    input  logic              ser_ack_i,
    input  logic              ser_done_i,
    input  logic [DATA_W-1:0] ser_rdata_i
);
    logic              cmd_fire;
    chan_cmd_t         new_cmd;
    chan_cmd_t         cur_cmd;
    logic              vclr_pulse;
    logic              init_done;
    chan_state_e       state;
    logic              sync_idle;
    logic [DATA_W-1:0] rdata;

    rac_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we_i),
        .bus_sel    (bus_sel_i),
        .bus_wdata  (bus_wdata_i),
        .fsm_idle   (state == ST_IDLE),
        .cmd_fire   (cmd_fire),
        .cmd        (new_cmd),
        .vclr_pulse (vclr_pulse),
        .init_done  (init_done),
        .err        (err_o)
    );

    rac_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd        (new_cmd),
        .vclr_pulse (vclr_pulse),
        .ser_ack    (ser_ack_i),
        .ser_done   (ser_done_i),
        .ser_rdata  (ser_rdata_i),
        .state      (state),
        .req        (ser_req_o),
        .sync_idle  (sync_idle),
        .cur_cmd    (cur_cmd),
        .rdata      (rdata)
    );

    rac_status_pack u_pack (
        .rdata     (rdata),
        .state     (state),
        .req       (ser_req_o),
        .sync_idle (sync_idle),
        .init_done (init_done),
        .status    (status_o)
    );

    assign ser_we_o    = cur_cmd.wr;
    assign ser_addr_o  = cur_cmd.addr;
    assign ser_wdata_o = cur_cmd.data;
endmodule

// File: rtl/reg_access_chan_chk.sv
module reg_access_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we_i,
    input logic [1:0]  bus_sel_i,
    input logic        vclr_bit,
    input logic [31:0] status_o,
    input logic        err_o,
    input logic        ser_req_o,
    input logic        ser_we_o,
    input logic        ser_ack_i,
    input logic        ser_done_i,
    input logic [15:0] ser_rdata_i
);
    logic [2:0] st;
    logic       vclr_wr;
    logic       cmd_wr;
    assign st      = status_o[18:16];
    assign vclr_wr = bus_we_i && (bus_sel_i == 2'd1) && vclr_bit;
    assign cmd_wr  = bus_we_i && (bus_sel_i == 2'd0);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0) || (st == 3'd2) || (st == 3'd4) || (st == 3'd6)); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[31:22] == 10'd0); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_req_o && !ser_ack_i) |=> ser_req_o); // R10
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_req_o && ser_ack_i) |=> (!ser_req_o && st == 3'd4)); // R10
    AST_WRITE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && ser_done_i && ser_we_o) |=> (st == 3'd0)); // R4
    AST_READ_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && ser_done_i && !ser_we_o) |=>
        (st == 3'd6 && status_o[15:0] == $past(ser_rdata_i))); // R5
    AST_VCLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && !vclr_wr) |=> (st == 3'd6 && $stable(status_o[15:0]))); // R6
    AST_VCLR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && vclr_wr) |=> (st == 3'd0)); // R6
    AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && status_o[21] && st != 3'd0) |=> err_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R7
    AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0 && !status_o[21]) |=> (st == 3'd0 && !ser_req_o)); // R8
    AST_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_req_o |-> !status_o[20]); // R9
endmodule

bind reg_access_chan reg_access_chan_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we_i    (bus_we_i),
    .bus_sel_i   (bus_sel_i),
    .vclr_bit    (bus_wdata_i[0]),
    .status_o    (status_o),
    .err_o       (err_o),
    .ser_req_o   (ser_req_o),
    .ser_we_o    (ser_we_o),
    .ser_ack_i   (ser_ack_i),
    .ser_done_i  (ser_done_i),
    .ser_rdata_i (ser_rdata_i)
);

// File: tb/sim_reg_access_chan.sv
`timescale 1ns/1ps
module sim_reg_access_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [1:0]  bus_sel_i = 2'd3;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] status_o;
    logic        err_o;
    logic        ser_req_o, ser_we_o;
    logic [14:0] ser_addr_o;
    logic [15:0] ser_wdata_o;
    logic        ser_ack_i = 1'b0;
    logic        ser_done_i = 1'b0;
    logic [15:0] ser_rdata_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    reg_access_chan u0 (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
        .bus_wdata_i(bus_wdata_i), .status_o(status_o), .err_o(err_o),
        .ser_req_o(ser_req_o), .ser_we_o(ser_we_o), .ser_addr_o(ser_addr_o),
        .ser_wdata_o(ser_wdata_o), .ser_ack_i(ser_ack_i), .ser_done_i(ser_done_i),
        .ser_rdata_i(ser_rdata_i)
    );

    function automatic logic [15:0] init_val(input int a);
        return 16'(a * 16'h0101) ^ 16'h5aa5;
    endfunction

    function automatic logic [31:0] mk_cmd(input logic wr, input logic [14:0] a,
                                           input logic [15:0] d);
        return {wr, a, d};
    endfunction

    // ---- behavioural serial engine stub ----
    logic [15:0] dev_mem [0:63];
    int          ph = 0;
    int          cnt = 0;
    logic        lat_we;
    logic [5:0]  lat_a;
    logic [15:0] lat_d;
    initial for (int i = 0; i < 64; i++) dev_mem[i] = init_val(i);

    always @(negedge clk) begin
        ser_ack_i  <= 1'b0;
        ser_done_i <= 1'b0;
        if (ph == 0) begin
            if (ser_req_o) begin
                cnt = $urandom_range(0, 3);
                ph  = 1;
            end
        end else if (ph == 1) begin
            if (cnt == 0) begin
                ser_ack_i <= 1'b1;
                lat_we = ser_we_o;
                lat_a  = ser_addr_o[5:0];
                lat_d  = ser_wdata_o;
                cnt    = $urandom_range(0, 4);
                ph     = 2;
            end else cnt--;
        end else begin
            if (cnt == 0) begin
                ser_done_i <= 1'b1;
                if (lat_we) dev_mem[lat_a] = lat_d;
                else        ser_rdata_i <= dev_mem[lat_a];
                ph = 0;
            end else cnt--;
        end
    end

    // ---- bench model and helpers ----
    logic [15:0] exp_mem [0:63];
    initial for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_sel_i = sel; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0; bus_sel_i = 2'd3;
    endtask

    task automatic wait_state(input logic [2:0] s);
        for (int i = 0; i < 40; i++) begin
            if (status_o[18:16] == s) break;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        bus_write(2'd0, mk_cmd(1'b1, 15'(a), d));
        exp_mem[a] = d;
        wait_state(3'd0);
        chk("R4 write returns to idle", {29'd0, status_o[18:16]}, 32'd0);
    endtask

    task automatic do_read(input int a);
        bus_write(2'd0, mk_cmd(1'b0, 15'(a), 16'h0));
        wait_state(3'd6);
        chk("R5 read data", {13'd0, status_o[18:16], status_o[15:0]},
            {13'd0, 3'd6, exp_mem[a]});
        bus_write(2'd1, 32'h1);
        chk("R6 valid-clear to idle", {29'd0, status_o[18:16]}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status_o, 32'h0010_0000);
        chk("R1 reset err/req", {30'd0, err_o, ser_req_o}, 32'd0);

        // R8: commands ignored while init-done is clear
        bus_write(2'd0, mk_cmd(1'b1, 15'd3, 16'hdead));
        repeat (3) @(negedge clk);
        chk("R8 gated cmd ignored", {28'd0, ser_req_o, status_o[18:16]}, 32'd0);
        chk("R8 gated cmd no error", {31'd0, err_o}, 32'd0);
        bus_write(2'd2, 32'h1);
        chk("R8 init-done visible", {31'd0, status_o[21]}, 32'd1);

        // R2/R3/R9/R10 write path details
        bus_write(2'd0, mk_cmd(1'b1, 15'd5, 16'ha55a));
        exp_mem[5] = 16'ha55a;
        chk("R3 pending: state/req/sync", {28'd0, status_o[20:19], status_o[18:17]},
            {28'd0, 2'b01, 2'b01});
        chk("R2 serial pins", {ser_we_o, ser_addr_o, ser_wdata_o},
            {1'b1, 15'd5, 16'ha55a});
        wait_state(3'd4);
        chk("R10 request dropped after accept", {31'd0, ser_req_o}, 32'd0);
        chk("R9 sync low in transfer", {31'd0, status_o[20]}, 32'd0);
        wait_state(3'd0);
        chk("R4 write done w/o valid-clear", {29'd0, status_o[18:16]}, 32'd0);
        chk("R9 sync back high", {31'd0, status_o[20]}, 32'd1);

        // R5/R6 read hold and valid-clear with bit0=0
        bus_write(2'd0, mk_cmd(1'b0, 15'd5, 16'h0));
        wait_state(3'd6);
        repeat (5) @(negedge clk);
        chk("R5 parked with data", {13'd0, status_o[18:16], status_o[15:0]},
            {13'd0, 3'd6, 16'ha55a});
        bus_write(2'd1, 32'h2);
        chk("R6 clear with bit0=0 ignored", {13'd0, status_o[18:16], status_o[15:0]},
            {13'd0, 3'd6, 16'ha55a});
        bus_write(2'd1, 32'h1);
        chk("R6 clear returns idle", {29'd0, status_o[18:16]}, 32'd0);

        // R7: command while busy is dropped and flags error
        bus_write(2'd0, mk_cmd(1'b0, 15'd7, 16'h0));
        bus_write(2'd0, mk_cmd(1'b1, 15'd7, 16'h1234));
        chk("R7 error raised", {31'd0, err_o}, 32'd1);
        wait_state(3'd6);
        chk("R7 read unaffected", {16'd0, status_o[15:0]}, {16'd0, exp_mem[7]});
        bus_write(2'd1, 32'h1);
        do_read(7);
        chk("R7 error sticky", {31'd0, err_o}, 32'd1);

        // R8: clearing init-done gates again
        bus_write(2'd2, 32'h0);
        bus_write(2'd0, mk_cmd(1'b0, 15'd1, 16'h0));
        repeat (2) @(negedge clk);
        chk("R8 re-gated", {28'd0, status_o[21], status_o[18:16]}, 32'd0);
        bus_write(2'd2, 32'h1);

        // random mix
        for (int k = 0; k < 160; k++) begin
            int a;
            a = $urandom_range(0, 63);
            if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom));
            else                           do_read(a);
        end
        for (int a = 0; a < 64; a += 9) do_read(a);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule